// File: doc/BRIEF.md
# Weighted Min-Max Variable Node Update for GF(4) Codes

This block updates the outgoing messages of one variable node in an iterative min-max decoder for a low-density parity-check code whose symbols live in GF(4). Every message is a vector of four unsigned reliability values, one per field symbol, where a smaller value marks a more likely symbol. For each of the node's edges the block adds the channel's intrinsic vector to the incoming check-to-variable vectors of all the other edges. It shifts the sum down so that its smallest entry becomes zero, then blends the result with the message the same edge carried in the previous iteration.

The blend is a weighted sum: a fraction beta of the fresh, normalized vector plus the fraction one minus beta of the stored vector. Beta is a fixed-point constant, BETA_NUM / 2^BETA_SH. Both products are built from shifts and adds, and the quotient is truncated toward zero. The surrounding decoder delivers a complete set of inputs for one node through a valid/ready handshake. It gets back all outgoing vectors a fixed three accepted cycles later and writes them into its message store. The permutation network, the check nodes, the memories and the iteration control sit outside this block.

Top module: `vn_weighted_node`

## Requirements
- R1: For edge e and symbol s, the pre-normalization value is the intrinsic value of symbol s plus the incoming extrinsic values of symbol s on every edge other than e. The edge's own extrinsic value is left out. Symbol s of edge e sits at bits [(e*4+s)*MSG_W +: MSG_W] of ext_i, prev_i and msg_o, and symbol s of intr_i at bits [s*IN_W +: IN_W].
- R2: A pre-normalization sum larger than 2^MSG_W-1 (1023 by default) is clamped to 2^MSG_W-1 instead of wrapping around.
- R3: The normalized vector of each edge is the clamped sum minus the smallest of its four entries. At least one entry is therefore zero, and the order of the entries is unchanged. When every entry is equal, the normalized vector is all zero.
- R4: Each output symbol equals floor((BETA_NUM*norm + (2^BETA_SH-BETA_NUM)*prev) / 2^BETA_SH). Here prev is the matching symbol of prev_i. The defaults are BETA_NUM=3 and BETA_SH=2, so beta is 0.75. The result is clamped to 2^MSG_W-1.
- R5: The result is also correct when the intrinsic vector alone decides it, that is, with zero extrinsic and zero previous inputs.
- R6: With out_ready held high, out_valid rises three clock edges after the edge at which in_valid and in_ready were both high. One input set is accepted per cycle, and the outputs come back in the order of acceptance.
- R7: While out_valid is high and out_ready is low, in_ready is low, msg_o holds its value and out_valid stays high.
- R8: After a synchronous active-low reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A full input set for one node is present |
| in_ready | output | 1 | The block accepts the input set at this edge |
| intr_i | input | 4*IN_W | Intrinsic channel reliabilities, one per symbol |
| ext_i | input | DEG*4*MSG_W | Incoming check-to-variable vectors, one per edge |
| prev_i | input | DEG*4*MSG_W | Stored previous outgoing vectors, one per edge |
| out_valid | output | 1 | msg_o holds a finished result |
| out_ready | input | 1 | The consumer takes msg_o at this edge |
| msg_o | output | DEG*4*MSG_W | New outgoing vectors, one per edge |

## Verification
An input set with zero extrinsic and zero previous vectors isolates the normalization. Distinct extrinsic vectors on each edge then show whether the block leaves out the right edge's own contribution. Large extrinsic values on lopsided symbols make clamping give a different answer from wrap-around or from an unclamped sum. Tied symbols are tried with and without a stored previous vector, and so are nonzero previous vectors, which separates the beta weight from the one-minus-beta weight and from the rounding. A random stream, first with the consumer always ready and then with random back-pressure, covers ordering, latency and holding the output while stalled.

// File: rtl/vn_pkg.sv
// Package: constants shared by the variable node pipeline.
// Assumes the field is GF(4): every message vector has four entries.
package vn_pkg;
    localparam int GF_Q      = 4;
    localparam int SYM_IDX_W = $clog2(GF_Q);
endpackage

// File: rtl/vn_edge_sum.sv
// Module: vn_edge_sum
// For every edge, adds the intrinsic vector to the extrinsic vectors of all
// the other edges and clamps each entry at the largest message value.
// Assumes MSG_W >= IN_W and unsigned reliabilities.
module vn_edge_sum
    import vn_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int MSG_W = 10,
    parameter int DEG   = 3
) (
    input  logic [GF_Q*IN_W-1:0]      intr_i,
    input  logic [DEG*GF_Q*MSG_W-1:0] ext_i,
    output logic [DEG*GF_Q*MSG_W-1:0] sum_o
);
    localparam int ACC_W = MSG_W + $clog2(DEG + 1);
    localparam logic [ACC_W-1:0] MAX_V = ACC_W'({MSG_W{1'b1}});

    for (genvar e = 0; e < DEG; e++) begin : g_edge
        for (genvar s = 0; s < GF_Q; s++) begin : g_sym
            logic [ACC_W-1:0] acc;

            // Wide sum over intrinsic plus every other edge, then clamp.
            always_comb begin
                acc = ACC_W'(intr_i[s*IN_W +: IN_W]);
                for (int k = 0; k < DEG; k++) begin
                    if (k != e) begin
                        acc = acc + ACC_W'(ext_i[(k*GF_Q+s)*MSG_W +: MSG_W]);
                    end
                end
            end

            // Saturate rather than wrap.
            always_comb begin
                if (acc > MAX_V) begin
                    sum_o[(e*GF_Q+s)*MSG_W +: MSG_W] = {MSG_W{1'b1}};
                end else begin
                    sum_o[(e*GF_Q+s)*MSG_W +: MSG_W] = acc[MSG_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/vn_norm.sv
// Module: vn_norm
// Finds the smallest of the four entries of one vector and subtracts it from
// every entry, so the result keeps its order and has at least one zero.
// Assumes unsigned entries.
module vn_norm
    import vn_pkg::*;
#(
    parameter int MSG_W = 10
) (
    input  logic [GF_Q*MSG_W-1:0] vec_i,
    output logic [GF_Q*MSG_W-1:0] norm_o
);
    logic [MSG_W-1:0] lo_pair [2];
    logic [MSG_W-1:0] min_v;

    // First level of the minimum tree: two pairwise comparisons.
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            if (vec_i[(2*p)*MSG_W +: MSG_W] <= vec_i[(2*p+1)*MSG_W +: MSG_W]) begin
                lo_pair[p] = vec_i[(2*p)*MSG_W +: MSG_W];
            end else begin
                lo_pair[p] = vec_i[(2*p+1)*MSG_W +: MSG_W];
            end
        end
    end

    // Second level of the minimum tree.
    always_comb begin
        min_v = (lo_pair[0] <= lo_pair[1]) ? lo_pair[0] : lo_pair[1];
    end

    // Subtract the minimum from every entry; never underflows.
    for (genvar s = 0; s < GF_Q; s++) begin : g_sub
        always_comb begin
            norm_o[s*MSG_W +: MSG_W] = vec_i[s*MSG_W +: MSG_W] - min_v;
        end
    end
endmodule

// File: rtl/vn_blend.sv
// Module: vn_blend
// Weighted sum of one normalized vector and its stored predecessor:
// floor((BETA_NUM*new + (2^BETA_SH-BETA_NUM)*old) / 2^BETA_SH), clamped.
// Constant products are formed from shifted copies only.
// Assumes 0 <= BETA_NUM <= 2^BETA_SH.
module vn_blend
    import vn_pkg::*;
#(
    parameter int MSG_W    = 10,
    parameter int BETA_NUM = 3,
    parameter int BETA_SH  = 2
) (
    input  logic [GF_Q*MSG_W-1:0] new_i,
    input  logic [GF_Q*MSG_W-1:0] old_i,
    output logic [GF_Q*MSG_W-1:0] mix_o
);
    localparam int PW      = MSG_W + BETA_SH + 2;
    localparam int OLD_NUM = (1 << BETA_SH) - BETA_NUM;
    localparam logic [PW-1:0] MAX_V = PW'({MSG_W{1'b1}});

    // Constant multiply by summing shifted copies for each set bit.
    function automatic logic [PW-1:0] cmul(input logic [MSG_W-1:0] x,
                                           input int unsigned c);
        logic [PW-1:0] acc;
        acc = '0;
        for (int b = 0; b <= BETA_SH; b++) begin
            if (c[b]) begin
                acc = acc + (PW'(x) << b);
            end
        end
        return acc;
    endfunction

    for (genvar s = 0; s < GF_Q; s++) begin : g_sym
        logic [PW-1:0] wsum;
        logic [PW-1:0] quo;

        // Weighted sum and truncating division by the power of two.
        always_comb begin
            wsum = cmul(new_i[s*MSG_W +: MSG_W], BETA_NUM)
                 + cmul(old_i[s*MSG_W +: MSG_W], OLD_NUM);
            quo  = wsum >> BETA_SH;
        end

        // Clamp to the message width.
        always_comb begin
            if (quo > MAX_V) begin
                mix_o[s*MSG_W +: MSG_W] = {MSG_W{1'b1}};
            end else begin
                mix_o[s*MSG_W +: MSG_W] = quo[MSG_W-1:0];
            end
        end
    end
endmodule

// File: rtl/vn_weighted_node.sv
// Module: vn_weighted_node (top)
// Three-stage pipeline for one variable node of degree DEG over GF(4):
//   stage 1 registers clamped per-edge sums and the stored messages,
//   stage 2 registers the normalized vectors,
//   stage 3 registers the blended outgoing vectors (msg_o).
// The whole pipeline advances together whenever the output stage is empty
// or being taken, which gives a fixed latency of three edges.
// Assumes synchronous active-low reset and MSG_W >= IN_W.
module vn_weighted_node
    import vn_pkg::*;
#(
    parameter int IN_W     = 10,
    parameter int MSG_W    = 10,
    parameter int DEG      = 3,
    parameter int BETA_NUM = 3,
    parameter int BETA_SH  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [GF_Q*IN_W-1:0]       intr_i,
    input  logic [DEG*GF_Q*MSG_W-1:0]  ext_i,
    input  logic [DEG*GF_Q*MSG_W-1:0]  prev_i,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DEG*GF_Q*MSG_W-1:0]  msg_o
);
    localparam int VEC_W = GF_Q * MSG_W;
    localparam int ALL_W = DEG * VEC_W;

    logic             advance;
    logic [ALL_W-1:0] sum_c;
    logic [ALL_W-1:0] norm_c;
    logic [ALL_W-1:0] mix_c;

    logic             s1_v;
    logic [ALL_W-1:0] s1_sum;
    logic [ALL_W-1:0] s1_prev;
    logic             s2_v;
    logic [ALL_W-1:0] s2_norm;
    logic [ALL_W-1:0] s2_prev;

    // Pipeline moves when the output register is free or being drained.
    always_comb begin
        advance  = !out_valid || out_ready;
        in_ready = advance;
    end

    vn_edge_sum #(
        .IN_W (IN_W),
        .MSG_W(MSG_W),
        .DEG  (DEG)
    ) u_edge_sum (
        .intr_i(intr_i),
        .ext_i (ext_i),
        .sum_o (sum_c)
    );

    for (genvar e = 0; e < DEG; e++) begin : g_edge
        vn_norm #(
            .MSG_W(MSG_W)
        ) u_norm (
            .vec_i (s1_sum[e*VEC_W +: VEC_W]),
            .norm_o(norm_c[e*VEC_W +: VEC_W])
        );

        vn_blend #(
            .MSG_W   (MSG_W),
            .BETA_NUM(BETA_NUM),
            .BETA_SH (BETA_SH)
        ) u_blend (
            .new_i(s2_norm[e*VEC_W +: VEC_W]),
            .old_i(s2_prev[e*VEC_W +: VEC_W]),
            .mix_o(mix_c[e*VEC_W +: VEC_W])
        );
    end

    // Valid bits of the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v      <= 1'b0;
            s2_v      <= 1'b0;
            out_valid <= 1'b0;
        end else if (advance) begin
            s1_v      <= in_valid;
            s2_v      <= s1_v;
            out_valid <= s2_v;
        end
    end

    // Data registers of the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sum  <= '0;
            s1_prev <= '0;
            s2_norm <= '0;
            s2_prev <= '0;
            msg_o   <= '0;
        end else if (advance) begin
            s1_sum  <= sum_c;
            s1_prev <= prev_i;
            s2_norm <= norm_c;
            s2_prev <= s1_prev;
            msg_o   <= mix_c;
        end
    end
endmodule

// File: rtl/vn_node_chk.sv
// Module: vn_node_chk
// Checker bound to vn_weighted_node: handshake holding, occupancy and the
// zero-entry property of the normalized vectors.
module vn_node_chk
    import vn_pkg::*;
#(
    parameter int MSG_W = 10,
    parameter int DEG   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [DEG*GF_Q*MSG_W-1:0] msg_o,
    input logic                      s2_v,
    input logic [DEG*GF_Q*MSG_W-1:0] s2_norm
);
    logic [3:0] inflight;
    logic       zero_each_edge;

    // Count accepted sets not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
        end
    end

    // Every edge's normalized vector must contain a zero entry.
    always_comb begin
        zero_each_edge = 1'b1;
        for (int e = 0; e < DEG; e++) begin
            logic hz;
            hz = 1'b0;
            for (int s = 0; s < GF_Q; s++) begin
                if (s2_norm[(e*GF_Q+s)*MSG_W +: MSG_W] == '0) hz = 1'b1;
            end
            if (!hz) zero_each_edge = 1'b0;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(msg_o)));

    // R7
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R6
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 4'd3);

    // R6
    out_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != 4'd0));

    // R3
    norm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_v |-> zero_each_edge);
endmodule

bind vn_weighted_node vn_node_chk #(
    .MSG_W(MSG_W),
    .DEG  (DEG)
) u_vn_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .msg_o    (msg_o),
    .s2_v     (s2_v),
    .s2_norm  (s2_norm)
);

// File: tb/vn_weighted_node_bench.sv
module vn_weighted_node_bench;
    localparam int CLK_P    = 10;
    localparam int IN_W     = 10;
    localparam int MSG_W    = 10;
    localparam int DEG      = 3;
    localparam int Q        = 4;
    localparam int BETA_NUM = 3;
    localparam int BETA_SH  = 2;
    localparam int ALL_W    = DEG * Q * MSG_W;
    localparam int MAXV     = (1 << MSG_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [Q*IN_W-1:0] intr_i = '0;
    logic [ALL_W-1:0] ext_i = '0;
    logic [ALL_W-1:0] prev_i = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [ALL_W-1:0] msg_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit rand_ready = 1'b0;
    string cur_tag = "R1";
    bit cur_lat = 1'b1;

    logic [ALL_W-1:0] exp_q[$];
    string            tag_q[$];
    int               cyc_q[$];
    bit               lat_q[$];

    bit               was_stalled = 1'b0;
    logic [ALL_W-1:0] held_msg;

    vn_weighted_node #(
        .IN_W(IN_W), .MSG_W(MSG_W), .DEG(DEG),
        .BETA_NUM(BETA_NUM), .BETA_SH(BETA_SH)
    ) u_vn_weighted_node (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .intr_i(intr_i), .ext_i(ext_i), .prev_i(prev_i),
        .out_valid(out_valid), .out_ready(out_ready), .msg_o(msg_o)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural reference: integer arithmetic straight from the requirements.
    function automatic logic [ALL_W-1:0] ref_model(input logic [Q*IN_W-1:0] it,
                                                   input logic [ALL_W-1:0] ex,
                                                   input logic [ALL_W-1:0] pv);
        logic [ALL_W-1:0] r;
        r = '0;
        for (int e = 0; e < DEG; e++) begin
            int sums[4];
            int mn;
            mn = MAXV;
            for (int s = 0; s < Q; s++) begin
                int t;
                t = int'(it[s*IN_W +: IN_W]);
                for (int k = 0; k < DEG; k++)
                    if (k != e) t += int'(ex[(k*Q+s)*MSG_W +: MSG_W]);
                if (t > MAXV) t = MAXV;
                sums[s] = t;
                if (t < mn) mn = t;
            end
            for (int s = 0; s < Q; s++) begin
                int o;
                o = (BETA_NUM * (sums[s] - mn)
                     + ((1 << BETA_SH) - BETA_NUM) * int'(pv[(e*Q+s)*MSG_W +: MSG_W]))
                    >> BETA_SH;
                if (o > MAXV) o = MAXV;
                r[(e*Q+s)*MSG_W +: MSG_W] = MSG_W'(o);
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input bit ok, input logic [ALL_W-1:0] act,
                         input logic [ALL_W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: sample away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (was_stalled) begin
                // R7: held output after a refused cycle
                check("R7 hold", out_valid && msg_o == held_msg, msg_o, held_msg);
            end
            if (out_valid && !out_ready) begin
                // R7: no new input accepted while stalled
                check("R7 in_ready", in_ready == 1'b0, ALL_W'(in_ready), '0);
                was_stalled = 1'b1;
                held_msg = msg_o;
            end else begin
                was_stalled = 1'b0;
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(ref_model(intr_i, ext_i, prev_i));
                tag_q.push_back(cur_tag);
                cyc_q.push_back(cyc);
                lat_q.push_back(cur_lat);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected output", 1'b0, msg_o, '0);
                end else begin
                    logic [ALL_W-1:0] ev;
                    string tg;
                    int c0;
                    bit lt;
                    ev = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    c0 = cyc_q.pop_front();
                    lt = lat_q.pop_front();
                    check(tg, msg_o == ev, msg_o, ev);
                    if (lt) check("R6 latency", (cyc - c0) == 3,
                                  ALL_W'(cyc - c0), ALL_W'(3));
                end
            end
        end
    end

    // Consumer readiness driven just after the edge.
    always @(posedge clk) begin
        #1;
        if (rand_ready) out_ready = ($urandom_range(0, 2) != 0);
        else out_ready = 1'b1;
    end

    function automatic logic [ALL_W-1:0] rand_vecs(input int hi);
        logic [ALL_W-1:0] v;
        for (int i = 0; i < DEG * Q; i++) v[i*MSG_W +: MSG_W] = MSG_W'($urandom_range(0, hi));
        return v;
    endfunction

    function automatic logic [Q*IN_W-1:0] mk_intr(input int a, input int b,
                                                  input int c, input int d);
        return {IN_W'(d), IN_W'(c), IN_W'(b), IN_W'(a)};
    endfunction

    function automatic logic [Q*MSG_W-1:0] mk_vec(input int a, input int b,
                                                  input int c, input int d);
        return {MSG_W'(d), MSG_W'(c), MSG_W'(b), MSG_W'(a)};
    endfunction

    task automatic send(input logic [Q*IN_W-1:0] it, input logic [ALL_W-1:0] ex,
                        input logic [ALL_W-1:0] pv, input string tg);
        bit ok;
        @(posedge clk); #2;
        cur_tag = tg;
        intr_i = it; ext_i = ex; prev_i = pv; in_valid = 1'b1;
        forever begin
            @(negedge clk); ok = in_ready;
            @(posedge clk); #2;
            if (ok) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (400) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !out_valid) break;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8 out_valid", out_valid == 1'b0, ALL_W'(out_valid), '0);
        check("R8 in_ready", in_ready == 1'b1, ALL_W'(in_ready), ALL_W'(1));

        // R5: intrinsic only, no extrinsic, no history
        send(mk_intr(40, 8, 100, 23), '0, '0, "R5 intrinsic only");
        drain();
        // R1: distinct extrinsic per edge, own edge left out
        send(mk_intr(5, 0, 9, 2),
             {mk_vec(0, 50, 0, 7), mk_vec(30, 0, 1, 0), mk_vec(1, 2, 200, 3)},
             '0, "R1 edge exclusion");
        drain();
        // R2: clamped sums differ from wrapped or unclamped sums
        send(mk_intr(1000, 1000, 10, 0),
             {mk_vec(500, 500, 500, 500), mk_vec(500, 500, 500, 500), mk_vec(500, 500, 500, 500)},
             '0, "R2 saturation");
        drain();
        // R3: tied entries normalize to zero
        send(mk_intr(200, 200, 200, 200), '0, '0, "R3 tie zero");
        drain();
        // R3/R4: tied entries with history -> one quarter of history
        send(mk_intr(77, 77, 77, 77), '0,
             {mk_vec(1023, 4, 3, 0), mk_vec(100, 101, 102, 103), mk_vec(8, 9, 10, 11)},
             "R4 tie with history");
        drain();
        // R4: weighted blend with rounding down
        send(mk_intr(13, 0, 6, 1),
             {mk_vec(3, 1, 0, 2), mk_vec(0, 9, 4, 4), mk_vec(5, 5, 0, 1)},
             {mk_vec(1, 2, 3, 5), mk_vec(1023, 1023, 0, 1), mk_vec(7, 0, 6, 9)},
             "R4 blend");
        drain();

        // R6: back-to-back random stream, consumer always ready
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #2;
            cur_tag = "R6 stream order";
            intr_i = {IN_W'($urandom_range(0, 1023)), IN_W'($urandom_range(0, 1023)),
                      IN_W'($urandom_range(0, 1023)), IN_W'($urandom_range(0, 1023))};
            ext_i = rand_vecs(600);
            prev_i = rand_vecs(1023);
            in_valid = 1'b1;
        end
        @(posedge clk); #2 in_valid = 1'b0;
        drain();

        // R7: random stream with back-pressure
        cur_lat = 1'b0;
        rand_ready = 1'b1;
        for (int i = 0; i < 60; i++) begin
            send({IN_W'($urandom_range(0, 1023)), IN_W'($urandom_range(0, 1023)),
                  IN_W'($urandom_range(0, 1023)), IN_W'($urandom_range(0, 1023))},
                 rand_vecs(1023), rand_vecs(1023), "R7 stalled stream");
        end
        rand_ready = 1'b0;
        drain();
        check("R6 all delivered", exp_q.size() == 0, ALL_W'(exp_q.size()), '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule